// File: doc/BRIEF.md
# PHY Test-Port Register Writer

This block programs a PHY whose configuration registers are reached only through a narrow, indirectly addressed test port. That port has four signals: a clear line, a strobe, an enable flag and an 8-bit data bus. A client sends single requests over a valid/ready handshake. Each request is either a register write, which carries a code and a value, or a clear of the PHY's test parameters.

A write runs in two phases, and each phase is closed by a strobe pulse that goes high and then low:

- **Address phase.** The register code is placed on the bus with the enable flag raised.
- **Data phase.** The value is placed on the bus with the enable flag low.

The PHY latches what is on the bus when the strobe falls. A clear raises the clear line and then drops it. A clear is only allowed while the PHY is held in reset.

A typical programming pass sends one clear, then five clock-lane timing codes, then seven timing codes for each active data lane, and finally six PHY/PLL configuration codes. The strobe high time and low time are set in system clocks by parameters. A parameter value of 0 is treated as 1.

Top module: `phy_tst_writer`

## Requirements
- R1: While reset is low, and on the first cycle after it, `req_ready` is 1 (for a write request) and `busy`, `done`, `tst_strobe`, `tst_clr`, `tst_en` and `tst_data` are all 0.
- R2: The cycle after a write request is accepted opens the address phase. `tst_data` carries the accepted code and `tst_en` is 1 for one setup cycle, then for the strobe-high cycles, then for the strobe-low cycles. A PHY sampling on the falling strobe while `tst_en` is 1 therefore captures the code.
- R3: The data phase follows directly. `tst_data` carries the accepted value with `tst_en` at 0, again for one setup cycle, the strobe-high cycles and the strobe-low cycles. A PHY sampling on the second falling strobe stores the value at the captured code.
- R4: Every strobe pulse stays high for exactly max(1, STROBE_HI) cycles. The done pulse comes exactly max(1, STROBE_LO) cycles after the final strobe falls.
- R5: `req_ready` is 0 and `busy` is 1 from the cycle after acceptance until the last low phase ends. This lasts 2·(1+H+L) cycles for a write and H+L cycles for a clear, where H and L are the effective high and low counts.
- R6: `done` is a single-cycle pulse in the first idle cycle after a transaction. In that same cycle `req_ready` is 1, so a request held valid is accepted back to back.
- R7: A clear drives `tst_clr` high for H cycles and then low for L cycles, with `tst_strobe` and `tst_en` at 0. The modelled PHY then reads 0 at every code.
- R8: A clear request (`req_clear`=1) is refused, with `req_ready` at 0 and no `tst_clr` pulse, while `phy_hold_rst` is 0. It is accepted once `phy_hold_rst` is 1. Write requests do not depend on `phy_hold_rst`.
- R9: `tst_data` and `tst_en` do not change while `tst_strobe` stays high, and `tst_strobe` and `tst_clr` are never high in the same cycle.
- R10: Code and value are captured at acceptance. Changes on `req_code` and `req_value` during a transaction do not affect what the PHY receives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted this cycle if valid |
| req_clear | input | 1 | 1 = clear request, 0 = register write |
| req_code | input | BUS_W | Register code for a write |
| req_value | input | BUS_W | Register value for a write |
| phy_hold_rst | input | 1 | 1 while the PHY is held in reset (permits clear) |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | One-cycle pulse when a transaction completes |
| tst_clr | output | 1 | Test-port clear line |
| tst_strobe | output | 1 | Test-port latch strobe |
| tst_en | output | 1 | Test-port enable: 1 = address phase, 0 = data phase |
| tst_data | output | BUS_W | Test-port data bus |

## Verification
Two functions can fall in the same cycle: the completion pulse of one transaction and the acceptance of the next request. The bench provokes this by keeping `req_valid` high with a new code and value while a write finishes. It then judges three things:

- `done` and `req_ready` are both sampled at 1 in that cycle.
- The following cycle shows `busy` again.
- The modelled PHY ends up holding both values at their own codes.

The refused-clear case is exercised by holding a clear request while `phy_hold_rst` is low.

// File: rtl/phy_tstw_pkg.sv
// Package: shared state encoding for the PHY test-port writer.
// Assumes: nothing beyond SystemVerilog enums.
package phy_tstw_pkg;

    // Sequencer phases: A* = address phase, D* = data phase, C* = clear.
    typedef enum logic [3:0] {
        ST_IDLE = 4'd0,
        ST_ASET = 4'd1,
        ST_AHI  = 4'd2,
        ST_ALO  = 4'd3,
        ST_DSET = 4'd4,
        ST_DHI  = 4'd5,
        ST_DLO  = 4'd6,
        ST_CHI  = 4'd7,
        ST_CLO  = 4'd8
    } tstw_state_e;

endpackage

// File: rtl/phy_tstw_timer.sv
// Module: down-counter that times strobe/clear high and low phases.
// Does: loads a count of (cycles-1) and reports expiry when it reaches 0.
// Assumes: load_val fits CNT_W; the counter holds at 0 until the next load.
module phy_tstw_timer #(
    parameter int CNT_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             expired
);

    logic [CNT_W-1:0] cnt_q;

    // Phase counter: reload on request, else count down to zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign expired = (cnt_q == '0);

endmodule

// File: rtl/phy_tstw_seq.sv
// Module: transaction sequencer of the PHY test-port writer.
// Does: runs address and data phases for writes, and high/low phases for
//       clears; owns the handshake, busy and done.
// Assumes: HI_CYC and LO_CYC are already clamped to at least 1.
module phy_tstw_seq
    import phy_tstw_pkg::*;
#(
    parameter int HI_CYC = 2,
    parameter int LO_CYC = 2,
    parameter int CNT_W  = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic             req_clear,
    input  logic             hold_ok,
    input  logic             tmr_expired,
    output tstw_state_e      state_q,
    output logic             req_ready,
    output logic             accept,
    output logic             tmr_load,
    output logic [CNT_W-1:0] tmr_val,
    output logic             busy,
    output logic             done
);

    localparam logic [CNT_W-1:0] HI_LD = CNT_W'(HI_CYC - 1);
    localparam logic [CNT_W-1:0] LO_LD = CNT_W'(LO_CYC - 1);

    tstw_state_e state_d;
    logic        finish;

    // Handshake: idle, and a clear only while the PHY is held in reset.
    always_comb begin
        req_ready = (state_q == ST_IDLE) && (!req_clear || hold_ok);
        accept    = req_valid && req_ready;
    end

    // Next-phase selection and timer loading.
    always_comb begin
        state_d  = state_q;
        tmr_load = 1'b0;
        tmr_val  = HI_LD;
        finish   = 1'b0;
        case (state_q)
            ST_IDLE: begin
                if (accept) begin
                    if (req_clear) begin
                        state_d  = ST_CHI;
                        tmr_load = 1'b1;
                        tmr_val  = HI_LD;
                    end else begin
                        state_d = ST_ASET;
                    end
                end
            end
            ST_ASET: begin
                state_d  = ST_AHI;
                tmr_load = 1'b1;
                tmr_val  = HI_LD;
            end
            ST_AHI: begin
                if (tmr_expired) begin
                    state_d  = ST_ALO;
                    tmr_load = 1'b1;
                    tmr_val  = LO_LD;
                end
            end
            ST_ALO: begin
                if (tmr_expired) begin
                    state_d = ST_DSET;
                end
            end
            ST_DSET: begin
                state_d  = ST_DHI;
                tmr_load = 1'b1;
                tmr_val  = HI_LD;
            end
            ST_DHI: begin
                if (tmr_expired) begin
                    state_d  = ST_DLO;
                    tmr_load = 1'b1;
                    tmr_val  = LO_LD;
                end
            end
            ST_DLO: begin
                if (tmr_expired) begin
                    state_d = ST_IDLE;
                    finish  = 1'b1;
                end
            end
            ST_CHI: begin
                if (tmr_expired) begin
                    state_d  = ST_CLO;
                    tmr_load = 1'b1;
                    tmr_val  = LO_LD;
                end
            end
            ST_CLO: begin
                if (tmr_expired) begin
                    state_d = ST_IDLE;
                    finish  = 1'b1;
                end
            end
            default: begin
                state_d = ST_IDLE;
            end
        endcase
    end

    // State and completion-pulse registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            done    <= 1'b0;
        end else begin
            state_q <= state_d;
            done    <= finish;
        end
    end

    assign busy = (state_q != ST_IDLE);

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R6

    AST_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> (busy && !req_ready)); // R5

endmodule

// File: rtl/phy_tstw_drive.sv
// Module: test-port pin driver of the PHY test-port writer.
// Does: captures code/value at acceptance and decodes the port pins from
//       the sequencer phase.
// Assumes: accept is only high in the idle phase.
module phy_tstw_drive
    import phy_tstw_pkg::*;
#(
    parameter int BUS_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             accept,
    input  logic [BUS_W-1:0] req_code,
    input  logic [BUS_W-1:0] req_value,
    input  tstw_state_e      state_q,
    output logic             tst_clr,
    output logic             tst_strobe,
    output logic             tst_en,
    output logic [BUS_W-1:0] tst_data
);

    logic [BUS_W-1:0] code_q;
    logic [BUS_W-1:0] value_q;
    logic             in_addr;
    logic             in_data;

    // Request capture: holds code and value for the whole transaction.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            code_q  <= '0;
            value_q <= '0;
        end else if (accept) begin
            code_q  <= req_code;
            value_q <= req_value;
        end
    end

    // Pin decode from the current phase.
    always_comb begin
        in_addr    = (state_q == ST_ASET) || (state_q == ST_AHI) || (state_q == ST_ALO);
        in_data    = (state_q == ST_DSET) || (state_q == ST_DHI) || (state_q == ST_DLO);
        tst_en     = in_addr;
        tst_strobe = (state_q == ST_AHI) || (state_q == ST_DHI);
        tst_clr    = (state_q == ST_CHI);
        tst_data   = in_addr ? code_q : (in_data ? value_q : '0);
    end

    AST_STB_CLR_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(tst_strobe && tst_clr)); // R9

    AST_BUS_HELD_HI: assert property (@(posedge clk) disable iff (!rst_n)
        (tst_strobe && $past(tst_strobe)) |-> ($stable(tst_data) && $stable(tst_en))); // R9

    AST_ADDR_AT_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(tst_strobe) && tst_en) |-> (tst_data == $past(tst_data))); // R2

endmodule

// File: rtl/phy_tst_writer.sv
// Module: top of the PHY test-port writer.
// Does: turns {code,value} write requests and clear requests into strobed
//       test-port sequences.
// Assumes: phy_hold_rst reflects the PHY reset state; strobe counts below 1
//          are treated as 1.
module phy_tst_writer
    import phy_tstw_pkg::*;
#(
    parameter int BUS_W     = 8,
    parameter int STROBE_HI = 2,
    parameter int STROBE_LO = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic             req_clear,
    input  logic [BUS_W-1:0] req_code,
    input  logic [BUS_W-1:0] req_value,
    input  logic             phy_hold_rst,
    output logic             busy,
    output logic             done,
    output logic             tst_clr,
    output logic             tst_strobe,
    output logic             tst_en,
    output logic [BUS_W-1:0] tst_data
);

    localparam int HI_EFF = (STROBE_HI < 1) ? 1 : STROBE_HI;
    localparam int LO_EFF = (STROBE_LO < 1) ? 1 : STROBE_LO;
    localparam int PH_MAX = (HI_EFF > LO_EFF) ? HI_EFF : LO_EFF;
    localparam int CNT_W  = (PH_MAX < 2) ? 1 : $clog2(PH_MAX);

    tstw_state_e      state_q;
    logic             accept;
    logic             tmr_load;
    logic [CNT_W-1:0] tmr_val;
    logic             tmr_expired;

    phy_tstw_seq #(
        .HI_CYC (HI_EFF),
        .LO_CYC (LO_EFF),
        .CNT_W  (CNT_W)
    ) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_valid   (req_valid),
        .req_clear   (req_clear),
        .hold_ok     (phy_hold_rst),
        .tmr_expired (tmr_expired),
        .state_q     (state_q),
        .req_ready   (req_ready),
        .accept      (accept),
        .tmr_load    (tmr_load),
        .tmr_val     (tmr_val),
        .busy        (busy),
        .done        (done)
    );

    phy_tstw_timer #(
        .CNT_W (CNT_W)
    ) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .expired  (tmr_expired)
    );

    phy_tstw_drive #(
        .BUS_W (BUS_W)
    ) u_drive (
        .clk        (clk),
        .rst_n      (rst_n),
        .accept     (accept),
        .req_code   (req_code),
        .req_value  (req_value),
        .state_q    (state_q),
        .tst_clr    (tst_clr),
        .tst_strobe (tst_strobe),
        .tst_en     (tst_en),
        .tst_data   (tst_data)
    );

    AST_CLR_UNDER_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tst_clr) |-> $past(phy_hold_rst)); // R8

endmodule

// File: tb/phy_tst_writer_test.sv
`timescale 1ns/1ps
module phy_tst_writer_test;

    localparam int H = 3;
    localparam int L = 2;
    localparam int WR_LEN = 2 * (1 + H + L);
    localparam int CL_LEN = H + L;
    localparam int NVEC = 26;

    // Programming pass: {is_clear, code, value}; clear, 5 clock-lane,
    // 7 per lane for two lanes, 6 configuration codes.
    localparam logic [16:0] PASS_VEC [NVEC] = '{
        {1'b1, 8'h00, 8'h00},
        {1'b0, 8'h10, 8'h03}, {1'b0, 8'h11, 8'h05}, {1'b0, 8'h12, 8'h1A},
        {1'b0, 8'h13, 8'h0C}, {1'b0, 8'h14, 8'hFF},
        {1'b0, 8'h20, 8'h03}, {1'b0, 8'h21, 8'h04}, {1'b0, 8'h22, 8'h0B},
        {1'b0, 8'h23, 8'h0E}, {1'b0, 8'h24, 8'h03}, {1'b0, 8'h25, 8'h04},
        {1'b0, 8'h26, 8'hFE},
        {1'b0, 8'h30, 8'h13}, {1'b0, 8'h31, 8'h14}, {1'b0, 8'h32, 8'h1B},
        {1'b0, 8'h33, 8'h1E}, {1'b0, 8'h34, 8'h13}, {1'b0, 8'h35, 8'h14},
        {1'b0, 8'h36, 8'hEF},
        {1'b0, 8'h40, 8'h06}, {1'b0, 8'h41, 8'h21}, {1'b0, 8'h42, 8'h02},
        {1'b0, 8'h43, 8'h01}, {1'b0, 8'h44, 8'h85}, {1'b0, 8'h45, 8'hB3}
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       req_valid = 1'b0;
    logic       req_clear = 1'b0;
    logic [7:0] req_code = 8'h00;
    logic [7:0] req_value = 8'h00;
    logic       phy_hold_rst = 1'b1;
    logic       req_ready, busy, done, tst_clr, tst_strobe, tst_en;
    logic [7:0] tst_data;

    logic       m_valid = 1'b0;
    logic       m_ready, m_busy, m_done, m_clr, m_stb, m_en;
    logic [7:0] m_data;

    int n_chk = 0;
    int n_fail = 0;

    always #2.5 clk = ~clk;

    phy_tst_writer #(.BUS_W(8), .STROBE_HI(H), .STROBE_LO(L)) uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_clear(req_clear), .req_code(req_code), .req_value(req_value),
        .phy_hold_rst(phy_hold_rst), .busy(busy), .done(done),
        .tst_clr(tst_clr), .tst_strobe(tst_strobe), .tst_en(tst_en), .tst_data(tst_data)
    );

    phy_tst_writer #(.BUS_W(8), .STROBE_HI(0), .STROBE_LO(0)) uut_min (
        .clk(clk), .rst_n(rst_n), .req_valid(m_valid), .req_ready(m_ready),
        .req_clear(1'b0), .req_code(8'h5C), .req_value(8'h77),
        .phy_hold_rst(1'b0), .busy(m_busy), .done(m_done),
        .tst_clr(m_clr), .tst_strobe(m_stb), .tst_en(m_en), .tst_data(m_data)
    );

    task automatic chk(input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
        end
    endtask

    // PHY model and timing monitor, sampled on the falling clock edge.
    logic [7:0] mreg [256];
    logic [7:0] addr_q = 8'h00;
    logic       prev_stb = 1'b0, prev_clr = 1'b0, prev_busy = 1'b0, prev_en = 1'b0;
    logic [7:0] prev_data = 8'h00;
    int hi_run = 0, clr_run = 0, busy_run = 0, last_busy = 0, since_fall = 0;
    int clr_rises = 0, stab_err = 0, excl_err = 0, exp_busy = 0;
    logic exp_write = 1'b1;

    always @(negedge clk) begin
        if (!rst_n) begin
            prev_stb = 1'b0; prev_clr = 1'b0; prev_busy = 1'b0;
            hi_run = 0; clr_run = 0; busy_run = 0;
        end else begin
            if (prev_stb && !tst_strobe) begin
                if (tst_en) addr_q = tst_data;
                else mreg[addr_q] = tst_data;
                since_fall = 0;
            end else begin
                since_fall++;
            end
            if (tst_strobe) hi_run++;
            else if (prev_stb) begin
                chk("R4 strobe high width", hi_run, H);
                hi_run = 0;
            end
            if (tst_strobe && prev_stb && (tst_data != prev_data || tst_en != prev_en))
                stab_err++;
            if (tst_strobe && tst_clr) excl_err++;
            if (tst_clr) begin
                if (!prev_clr) begin
                    clr_rises++;
                    for (int i = 0; i < 256; i++) mreg[i] = 8'h00;
                end
                clr_run++;
                if (tst_strobe || tst_en) excl_err++;
            end else if (prev_clr) begin
                chk("R7 clear high width", clr_run, H);
                clr_run = 0;
            end
            if (busy) busy_run++;
            else if (prev_busy) begin
                last_busy = busy_run;
                busy_run = 0;
            end
            if (done) begin
                chk("R5 busy length", last_busy, exp_busy);
                if (exp_write) chk("R4 low phase before done", since_fall, L);
            end
            prev_stb = tst_strobe; prev_clr = tst_clr; prev_busy = busy;
            prev_en = tst_en; prev_data = tst_data;
        end
    end

    // One request; request fields are scrambled after acceptance (R10).
    task automatic do_req(input logic k, input logic [7:0] c, input logic [7:0] v);
        exp_write = !k;
        exp_busy = k ? CL_LEN : WR_LEN;
        @(negedge clk);
        req_valid = 1'b1; req_clear = k; req_code = c; req_value = v;
        while (!req_ready) @(negedge clk);
        @(negedge clk);
        req_valid = 1'b0; req_code = ~c; req_value = ~v;
        chk("R5 busy after accept", {busy, req_ready}, 2'b10);
        while (!done) @(negedge clk);
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired actual=0 expected=1");
        finish_run();
    end

    initial begin
        int busy_len, stb_len, rises0;
        for (int i = 0; i < 256; i++) mreg[i] = 8'hEE;
        repeat (3) @(negedge clk);
        chk("R1 reset ready", req_ready, 1);
        chk("R1 reset outputs", {busy, done, tst_strobe, tst_clr, tst_en}, 0);
        chk("R1 reset data", tst_data, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 idle after reset", {req_ready, busy, done, tst_strobe, tst_clr, tst_en}, 6'b100000);

        // Table walk: full programming pass.
        for (int i = 0; i < NVEC; i++) begin
            do_req(PASS_VEC[i][16], PASS_VEC[i][15:8], PASS_VEC[i][7:0]);
            @(negedge clk);
        end
        for (int i = 0; i < NVEC; i++) begin
            if (!PASS_VEC[i][16])
                chk("R2 R3 R10 PHY register content", mreg[PASS_VEC[i][15:8]], PASS_VEC[i][7:0]);
        end
        chk("R7 unwritten code cleared", mreg[8'hFF], 0);
        chk("R7 one clear pulse", clr_rises, 1);

        // Clear refused without PHY reset hold, then accepted.
        rises0 = clr_rises;
        @(negedge clk);
        phy_hold_rst = 1'b0; req_valid = 1'b1; req_clear = 1'b1;
        repeat (8) @(negedge clk);
        chk("R8 clear refused ready", req_ready, 0);
        chk("R8 clear refused busy", busy, 0);
        chk("R8 no clear pulse", clr_rises, rises0);
        exp_write = 1'b0; exp_busy = CL_LEN;
        phy_hold_rst = 1'b1;
        @(negedge clk);
        req_valid = 1'b0; req_clear = 1'b0;
        while (!done) @(negedge clk);
        chk("R8 clear taken under hold", clr_rises, rises0 + 1);
        @(negedge clk);

        // Back-to-back writes with PHY hold low (writes unaffected, R8).
        phy_hold_rst = 1'b0;
        exp_write = 1'b1; exp_busy = WR_LEN;
        req_valid = 1'b1; req_clear = 1'b0; req_code = 8'h61; req_value = 8'hA1;
        while (!req_ready) @(negedge clk);
        @(negedge clk);
        req_code = 8'h62; req_value = 8'hA2;
        while (!done) @(negedge clk);
        chk("R6 done and ready together", {done, req_ready}, 2'b11);
        @(negedge clk);
        req_valid = 1'b0;
        chk("R6 back-to-back accepted", busy, 1);
        @(negedge clk);
        while (!done) @(negedge clk);
        chk("R6 first write landed", mreg[8'h61], 8'hA1);
        chk("R6 second write landed", mreg[8'h62], 8'hA2);

        // Clamped-count instance: high and low counts of 0 behave as 1.
        @(negedge clk);
        m_valid = 1'b1;
        @(negedge clk);
        m_valid = 1'b0;
        busy_len = 0; stb_len = 0;
        while (!m_done) begin
            if (m_busy) busy_len++;
            if (m_stb) stb_len++;
            @(negedge clk);
        end
        chk("R4 clamped busy length", busy_len, 6);
        chk("R4 clamped strobe cycles", stb_len, 2);

        chk("R9 bus stable while strobe high", stab_err, 0);
        chk("R9 strobe and clear exclusive", excl_err, 0);
        finish_run();
    end

endmodule